// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

A clocked single-port memory with a built-in four-beat burst sequencer. It is meant as a synthesizable model of a pipelined burst SRAM. Each word holds a number of byte lanes, and each lane carries its own parity bit. On every rising clock edge where the active-low clock enable is low, the core samples its controls. A low `adv_ld` on such an edge starts a new access at the external address. A high `adv_ld` steps an internal two-bit counter through the remaining beats of the current group of four. The `order_sel` strap picks the beat order, linear or interleaved.

Reads and writes have the same one-edge latency. A read returns its word in the cycle after the edge that captured the address. A write takes its data at the qualified edge that follows its address edge, so the bus needs no idle cycle when the direction changes. The bidirectional bus is split into `wdata`, `rdata` and a `drive_en` strobe. `drive_en` tells a pad wrapper when the core may drive.

Top module: `sburst_sram`

## Requirements
- R1: While `clk_en_n` is high, the core ignores a rising edge. Address, write enable, byte enables, selects, `adv_ld` and `wdata` have no effect on that edge.
- R2: An edge with `clk_en_n` high holds every stage. This covers the burst position, any pending write, the read word on `rdata` and the drive state. It does not deselect the core, and the sequence resumes exactly where it stopped.
- R3: An edge with `adv_ld` low starts an access only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. Any other select combination deselects: it causes no write, and `drive_en` is low in the following cycle.
- R4: On an advance edge (`adv_ld`=1 while a burst is live), `we_n` and the three selects are ignored. The beat repeats the access type of the load that opened the burst. `byte_en_n` is sampled afresh on every beat.
- R5: With `order_sel`=1 (interleaved), beat k of a burst uses the load address with its two low bits XORed with k. The upper address bits stay fixed.
- R6: With `order_sel`=0 (linear), beat k uses the low two bits of the load address plus k, modulo 4. The upper address bits stay fixed.
- R7: A write beat takes its data from `wdata` at the next qualified edge. `byte_en_n[b]` low, sampled with the beat's address, writes lane b. Lane b is bits 9b+7..9b (data) together with bit 9b+8 (its parity bit). The other lanes keep their contents.
- R8: A read beat presents its word on `rdata` in the cycle after its address edge. If a write's data lands on that same edge at that address, the read returns the newly written lanes.
- R9: `drive_en` is high only when `oe_n` is low and the previous qualified edge issued a read beat. It is therefore low in the data phase of a write, in the first cycle after leaving deselect, and while deselected.
- R10: An advance edge that follows a deselect does not start an access. It acts as a further deselect: no write and no drive.
- R11: While `rst_n` is low, and after its release, no burst is live, no write is pending and `drive_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock qualifier, active low; high stalls everything |
| adv_ld | input | 1 | 0 = load new address, 1 = advance burst |
| addr | input | ADDR_W | Word address for a load |
| we_n | input | 1 | Write enable on a load, active low |
| byte_en_n | input | BYTES | Per-lane write enables, active low |
| sel1_n | input | 1 | Select, active low |
| sel2 | input | 1 | Select, active high |
| sel3_n | input | 1 | Select, active low |
| order_sel | input | 1 | Burst order strap: 1 interleaved, 0 linear |
| oe_n | input | 1 | Output enable, active low |
| wdata | input | BYTES*(BYTE_W+1) | Write word, lanes with parity |
| rdata | output | BYTES*(BYTE_W+1) | Read word |
| drive_en | output | 1 | Core may drive the shared bus |

## Verification
The hardest case to reach from the ports is a beat whose meaning depends on history rather than on its own inputs. Examples are an advance arriving after a deselect, or an advance carrying a low `we_n` and bad selects in the middle of a read burst. Both look like accesses at the pins. Another such case is a stall edge that falls between a write's address and its data. The stimulus builds these on purpose. It puts deselect loads and stalls directly in front of advances, gives the write data phase to a deselect or to a read load of the same address, and then reads the affected words back. A random phase over a small preloaded address window then mixes all of these cases, and a behavioural model is compared on every clock.

// File: rtl/sburst_pkg.sv
package sburst_pkg;

    localparam int CNT_W = 2;

    typedef logic [CNT_W-1:0] bcnt_t;

    // low address bits for a given beat of a burst
    function automatic bcnt_t burst_lo(bcnt_t start, bcnt_t step, logic interleave);
        return interleave ? (start ^ step) : bcnt_t'(start + step);
    endfunction

endpackage

// File: rtl/sburst_addr_gen.sv
module sburst_addr_gen
    import sburst_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  bcnt_t             step,
    input  logic              interleave,
    output logic [ADDR_W-1:0] addr_out
);

    // upper bits pinned to the burst's load address; low bits sequenced
    assign addr_out = {base_addr[ADDR_W-1:CNT_W],
                       burst_lo(base_addr[CNT_W-1:0], step, interleave)};

endmodule

// File: rtl/sburst_store.sv
module sburst_store #(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [BYTES-1:0]        wmask,
    input  logic [BYTES*LANE_W-1:0] wdata,
    input  logic                    re,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [BYTES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] wlane;
        logic [LANE_W-1:0] rlane_q;
        logic              fwd;

        assign wlane = wdata[b*LANE_W +: LANE_W];
        assign fwd   = we && wmask[b] && (waddr == raddr);

        always_ff @(posedge clk) begin
            if (we && wmask[b]) begin
                mem[waddr] <= wlane;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rlane_q <= '0;
            end else if (re) begin
                rlane_q <= fwd ? wlane : mem[raddr];
            end
        end

        assign rdata[b*LANE_W +: LANE_W] = rlane_q;
    end

endmodule

// File: rtl/sburst_sram.sv
module sburst_sram
    import sburst_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                clk_en_n,
    input  logic                                adv_ld,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic                                we_n,
    input  logic [BYTES-1:0]                    byte_en_n,
    input  logic                                sel1_n,
    input  logic                                sel2,
    input  logic                                sel3_n,
    input  logic                                order_sel,
    input  logic                                oe_n,
    input  logic [BYTES*(BYTE_W+1)-1:0]         wdata,
    output logic [BYTES*(BYTE_W+1)-1:0]         rdata,
    output logic                                drive_en
);

    localparam int LANE_W = BYTE_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        bcnt_t             cnt;
        logic              is_wr;
        logic              live;
        logic              rd;
        logic              wr_pend;
        logic [ADDR_W-1:0] wr_addr;
        logic [BYTES-1:0]  wr_mask;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic              qual, sel, acc, acc_wr;
    logic [ADDR_W-1:0] acc_addr, burst_addr;
    bcnt_t             cnt_nx;

    assign qual   = !clk_en_n;
    assign sel    = !sel1_n && sel2 && !sel3_n;
    assign cnt_nx = bcnt_t'(ctl_q.cnt + 1'b1);

    sburst_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .base_addr (ctl_q.base),
        .step      (cnt_nx),
        .interleave(order_sel),
        .addr_out  (burst_addr)
    );

    always_comb begin
        ctl_d    = ctl_q;
        acc      = 1'b0;
        acc_wr   = ctl_q.is_wr;
        acc_addr = burst_addr;
        if (qual) begin
            if (!adv_ld) begin
                if (sel) begin
                    ctl_d.base  = addr;
                    ctl_d.cnt   = '0;
                    ctl_d.is_wr = !we_n;
                    ctl_d.live  = 1'b1;
                    acc         = 1'b1;
                    acc_wr      = !we_n;
                    acc_addr    = addr;
                end else begin
                    ctl_d.live  = 1'b0;
                end
            end else if (ctl_q.live) begin
                ctl_d.cnt = cnt_nx;
                acc       = 1'b1;
            end
            ctl_d.rd      = acc && !acc_wr;
            ctl_d.wr_pend = acc && acc_wr;
            ctl_d.wr_addr = acc_addr;
            ctl_d.wr_mask = ~byte_en_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    sburst_store #(.ADDR_W(ADDR_W), .BYTES(BYTES), .LANE_W(LANE_W)) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (qual && ctl_q.wr_pend),
        .waddr(ctl_q.wr_addr),
        .wmask(ctl_q.wr_mask),
        .wdata(wdata),
        .re   (acc && !acc_wr),
        .raddr(acc_addr),
        .rdata(rdata)
    );

    assign drive_en = !oe_n && ctl_q.rd;

    AST_STALL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> $stable(rdata)); // R2

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (qual && !adv_ld && !sel) |=> (!drive_en && !ctl_q.wr_pend)); // R3

    AST_WRITE_PHASE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.wr_pend |-> !drive_en); // R9

    AST_ORPHAN_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (qual && adv_ld && !ctl_q.live) |=> (!drive_en && !ctl_q.wr_pend)); // R10

    AST_WRITE_LOAD_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (qual && !adv_ld && sel && !we_n) |=> ctl_q.wr_pend); // R7

endmodule

// File: tb/sburst_sram_tb.sv
module sburst_sram_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int NB = 4;
    localparam int WW = 36;
    localparam logic [2:0] CS_OK = 3'b010; // {sel1_n, sel2, sel3_n}

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b0;
    logic          adv_ld = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          we_n = 1'b1;
    logic [NB-1:0] byte_en_n = '1;
    logic          sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
    logic          order_sel = 1'b0;
    logic          oe_n = 1'b0;
    logic [WW-1:0] wdata = '0;
    logic [WW-1:0] rdata;
    logic          drive_en;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R11";

    always #(CLK_PERIOD/2) clk = ~clk;

    sburst_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_ld(adv_ld),
        .addr(addr), .we_n(we_n), .byte_en_n(byte_en_n), .sel1_n(sel1_n),
        .sel2(sel2), .sel3_n(sel3_n), .order_sel(order_sel), .oe_n(oe_n),
        .wdata(wdata), .rdata(rdata), .drive_en(drive_en)
    );

    // behavioural reference
    logic [WW-1:0] mem_m [int];
    int            m_base = 0, m_cnt = 0, m_pwa = 0;
    bit            m_live = 0, m_iswr = 0, m_rd = 0, m_pw = 0;
    logic [NB-1:0] m_pmask = '0;
    logic [WW-1:0] m_rdata = '0;

    task automatic model_edge();
        bit sel_ok;
        bit acc;
        int a;
        int lo;
        logic [WW-1:0] w;
        if (!rst_n) begin
            m_live = 0; m_rd = 0; m_pw = 0; m_rdata = '0;
            return;
        end
        if (clk_en_n) return;
        if (m_pw) begin
            w = mem_m.exists(m_pwa) ? mem_m[m_pwa] : '0;
            for (int b = 0; b < NB; b++)
                if (m_pmask[b]) w[b*9 +: 9] = wdata[b*9 +: 9];
            mem_m[m_pwa] = w;
        end
        sel_ok = (sel1_n == 0) && (sel2 == 1) && (sel3_n == 0);
        acc = 0;
        a = 0;
        if (!adv_ld) begin
            if (sel_ok) begin
                m_live = 1; m_base = int'(addr); m_cnt = 0; m_iswr = !we_n;
                acc = 1; a = int'(addr);
            end else begin
                m_live = 0;
            end
        end else if (m_live) begin
            m_cnt = (m_cnt + 1) % 4;
            lo = order_sel ? ((m_base % 4) ^ m_cnt) : (((m_base % 4) + m_cnt) % 4);
            a = (m_base / 4) * 4 + lo;
            acc = 1;
        end
        m_pw = acc && m_iswr;
        m_pwa = a;
        m_pmask = ~byte_en_n;
        m_rd = acc && !m_iswr;
        if (m_rd) m_rdata = mem_m.exists(a) ? mem_m[a] : 'x;
    endtask

    task automatic compare();
        logic exp_drv;
        exp_drv = !oe_n && m_rd;
        checks++;
        if (drive_en !== exp_drv) begin
            fails++;
            $display("FAIL %s drive_en actual=%b expected=%b", cur_req, drive_en, exp_drv);
        end
        if (exp_drv) begin
            checks++;
            if (rdata !== m_rdata) begin
                fails++;
                $display("FAIL %s rdata actual=%h expected=%h", cur_req, rdata, m_rdata);
            end
        end
    endtask

    task automatic cyc(input logic cen, input logic ld_adv, input logic wen,
                       input logic [NB-1:0] ben, input logic [2:0] cs,
                       input int a, input logic [WW-1:0] wd, input logic oe);
        clk_en_n = cen; adv_ld = ld_adv; we_n = wen; byte_en_n = ben;
        {sel1_n, sel2, sel3_n} = cs; addr = AW'(a); wdata = wd; oe_n = oe;
        @(posedge clk);
        model_edge();
        #1;
        compare();
        @(negedge clk);
    endtask

    task automatic ld_rd(input int a, input logic [WW-1:0] wd);
        cyc(0, 0, 1, '1, CS_OK, a, wd, 0);
    endtask
    task automatic ld_wr(input int a, input logic [NB-1:0] ben, input logic [WW-1:0] wd);
        cyc(0, 0, 0, ben, CS_OK, a, wd, 0);
    endtask
    task automatic adv(input logic [WW-1:0] wd);
        cyc(0, 1, 1, '0, CS_OK, 0, wd, 0);
    endtask
    task automatic nop(input logic [WW-1:0] wd);
        cyc(0, 0, 1, '1, 3'b111, 0, wd, 0);
    endtask
    task automatic stall();
        cyc(1, 0, 0, '0, CS_OK, 3, 36'hBADBADBAD, 0);
    endtask

    function automatic logic [WW-1:0] rnd_word();
        return {4'($urandom), 32'($urandom)};
    endfunction

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired (run hung)");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R11: reset state, oe_n low so only internal state can block drive
        cur_req = "R11";
        repeat (3) ld_rd(0, '0);
        rst_n = 1'b1;
        nop('0);

        // R7: preload all of 0..15 with linear write bursts at varied offsets
        cur_req = "R7";
        order_sel = 1'b0;
        for (int g = 0; g < 4; g++) begin
            ld_wr(g * 4 + g, '0, '0);
            adv(rnd_word());
            adv(rnd_word());
            adv(rnd_word());
            nop(rnd_word());
        end

        // R6: linear read bursts with wrap
        cur_req = "R6";
        ld_rd(7, '0); adv('0); adv('0); adv('0);
        ld_rd(13, '0); adv('0); adv('0); adv('0);

        // R5: interleaved order
        cur_req = "R5";
        order_sel = 1'b1;
        ld_rd(6, '0); adv('0); adv('0); adv('0);
        ld_rd(9, '0); adv('0); adv('0); adv('0);
        order_sel = 1'b0;

        // R7: partial lane write, lanes 0 and 2 enabled
        cur_req = "R7";
        ld_wr(5, 4'b1010, '0);
        nop(rnd_word());
        ld_rd(5, '0);
        ld_wr(2, 4'b0111, '0);
        adv(rnd_word());   // beat to addr 3 with all lanes enabled
        nop(rnd_word());
        ld_rd(2, '0); adv('0);

        // R8: read the address whose write data lands on the same edge
        cur_req = "R8";
        ld_wr(10, '0, '0);
        ld_rd(10, rnd_word());
        adv('0);

        // R2: stalls inside a read burst and between write address and data
        cur_req = "R2";
        ld_rd(12, '0); stall(); stall(); adv('0); stall(); adv('0); adv('0);
        ld_wr(14, '0, '0); stall(); nop(rnd_word()); ld_rd(14, '0);

        // R1: stall edges with a full write load presented are ignored
        cur_req = "R1";
        ld_rd(4, '0); stall(); stall(); stall(); adv('0);
        ld_rd(3, '0);

        // R4: advances carry bad selects and we_n low but keep reading
        cur_req = "R4";
        ld_rd(0, '0);
        cyc(0, 1, 0, '0, 3'b111, 9, rnd_word(), 0);
        cyc(0, 1, 0, '0, 3'b000, 9, rnd_word(), 0);
        cyc(0, 1, 0, '0, 3'b101, 9, rnd_word(), 0);
        ld_wr(8, '0, '0);
        cyc(0, 1, 1, '0, 3'b111, 0, rnd_word(), 0);
        cyc(0, 1, 1, 4'b1100, 3'b111, 0, rnd_word(), 0);
        cyc(0, 1, 1, '0, 3'b111, 0, rnd_word(), 0);
        nop(rnd_word());
        ld_rd(8, '0); adv('0); adv('0); adv('0);

        // R3: loads with each wrong select pattern do not write
        cur_req = "R3";
        cyc(0, 0, 0, '0, 3'b110, 11, '0, 0); nop(rnd_word());
        cyc(0, 0, 0, '0, 3'b000, 11, '0, 0); nop(rnd_word());
        cyc(0, 0, 0, '0, 3'b011, 11, '0, 0); nop(rnd_word());
        cyc(0, 0, 1, '1, 3'b011, 11, '0, 0);
        ld_rd(11, '0);

        // R10: advances after a deselect stay deselected
        cur_req = "R10";
        nop('0);
        cyc(0, 1, 0, '0, CS_OK, 1, rnd_word(), 0);
        cyc(0, 1, 0, '0, CS_OK, 1, rnd_word(), 0);
        nop(rnd_word());
        ld_rd(1, '0); adv('0);

        // R9: oe_n high, write data phase, first cycle out of deselect
        cur_req = "R9";
        ld_rd(1, '0);
        cyc(0, 1, 1, '0, CS_OK, 0, '0, 1);
        adv('0);
        ld_wr(4, '0, '0);
        ld_rd(4, rnd_word());
        nop('0);
        ld_rd(5, '0);
        adv('0);

        // random mix over the preloaded window
        cur_req = "R8";
        for (int i = 0; i < 600; i++) begin
            logic [2:0] cs;
            cs = ($urandom % 5 == 0) ? 3'($urandom) : CS_OK;
            if (i % 150 == 0) order_sel = $urandom % 2;
            cyc(($urandom % 6) == 0, ($urandom % 2), ($urandom % 2),
                4'($urandom), cs, $urandom % 16, rnd_word(), ($urandom % 5) == 0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule